// File: doc/BRIEF.md
# Triggered Trace Capture Buffer

This block keeps a short history of bus activity for a debug host. The host selects one of three capture modes, then writes 1 to the arm bit. While armed, the unit records either program-flow addresses (each taken branch, jump or call reported on the change-of-flow strobe) or data bus values, into an 8-slot ring. Trigger match pulses come from comparator logic outside this block. A match either starts or stops the recording, or, in data capture, chooses the sample to record.

Mode codes on `mode_sel`:

| Code | Mode | Behaviour |
|------|------|-----------|
| 2'b00 | start-on-trigger | Addresses are recorded only after a match. |
| 2'b01 | stop-on-trigger | Addresses are recorded from arming onward. A match freezes the last eight. |
| 2'b10 | data sample | Each match records the data bus. |
| 2'b11 | reserved | Arming with this code is refused. |

After a run the host pulls entries out one at a time with a read strobe, oldest first, while watching the valid-entry count. A run that the host stops by hand before the ring is full leaves a zero marker word ahead of the oldest record. The rest of the contents therefore sit one slot further along.

The controller has three states:

| State | Meaning |
|-------|---------|
| ST_IDLE | Disarmed. Reads are allowed. |
| ST_WAIT | Armed in start-on-trigger mode, waiting for the first match. |
| ST_RUN | Recording. |

Its transitions are:

- **arm** (any state): to ST_WAIT for code 00, or to ST_RUN for 01 or 10.
- **halt** (ST_WAIT or ST_RUN): to ST_IDLE.
- **trigger** (ST_WAIT): to ST_RUN.
- **fill** (ST_RUN, code 00 or 10): to ST_IDLE.
- **stop** (ST_RUN, code 01): to ST_IDLE.

Top module: `trc_fifo`

## Requirements
- R1: After reset, `count` is 0, `armed` is 0, `trig_hit` is 0 and `rd_data` is 0.
- R2: An arm write with `arm_wdata`=1 and a mode code of 00, 01 or 10 makes `armed` 1 at the next edge and clears the count, both ring positions and `trig_hit`. The same write with code 11 has no effect.
- R3: In code 00, change-of-flow strobes are not stored until a match arrives. A strobe in the match cycle itself is not stored. After that, every strobe stores `cof_addr`.
- R4: In code 01, every change-of-flow strobe stores `cof_addr` from arming onward. Once eight are held, each new one replaces the oldest and the count stays 8. A match disarms the unit, and a strobe in that cycle is not stored. The readout is then the last eight addresses, oldest first.
- R5: In code 10, each match stores `data_in` in the low 8 bits of the entry with the upper 8 bits zero. Change-of-flow strobes are ignored.
- R6: `count` gives the number of valid entries, from 0 up to 8 (4'b1000, full). In codes 00 and 10, the store that brings the count to 8 also clears `armed` at the same edge.
- R7: `rd_data` shows the oldest entry. A read strobe while disarmed with a nonzero count moves to the next entry and lowers the count by one, so entries come out in stored order. With the count at 0, `rd_data` is 0 and a strobe does nothing.
- R8: A read strobe while armed is ignored.
- R9: An arm write of 0 while armed with a count below 8 disarms the unit and places one zero word ahead of the oldest entry. The count rises by one and the first read returns 0. With the count at 8, the unit only disarms.
- R10: While disarmed, matches and change-of-flow strobes store nothing.
- R11: In a cycle with any arm write, that cycle's match, change-of-flow strobe and read strobe are all ignored.
- R12: `trig_hit` goes to 1 on any match while armed and holds until the next accepted arm write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Arm bit value written |
| mode_sel | input | 2 | Capture mode code, taken on an accepted arm write |
| match | input | 1 | Trigger match pulse |
| cof_vld | input | 1 | Change-of-flow strobe |
| cof_addr | input | 16 | Change-of-flow target address |
| data_in | input | 8 | Data bus value |
| rd_stb | input | 1 | Read strobe: advance to next entry |
| rd_data | output | 16 | Oldest valid entry, or 0 when empty |
| count | output | 4 | Number of valid entries |
| armed | output | 1 | Unit armed |
| trig_hit | output | 1 | A match was seen in this run |

## Verification
Two collisions matter most. The first is a host arm or halt write landing in the same cycle as a match or change-of-flow strobe. The second is a match coinciding with a change-of-flow strobe in the two address-trace modes. Directed cycles drive each pair together, for example a halt carrying a strobe, or arming while a match pulses. The bench then checks that the count, `armed` and the later readout reflect only the winning action. A seeded random phase raises these overlaps often. It compares every cycle against a bench-side reference model built from the requirements.

// File: rtl/trc_fifo_pkg.sv
package trc_fifo_pkg;

    typedef enum logic [1:0] {
        MODE_BEGIN = 2'b00,
        MODE_END   = 2'b01,
        MODE_DATA  = 2'b10,
        MODE_RSV   = 2'b11
    } trc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_RUN  = 2'b10
    } trc_state_e;

endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
    import trc_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_wr,
    input  logic          arm_wdata,
    input  logic [1:0]    mode_in,
    input  logic          match,
    input  logic          cof_vld,
    input  logic [CW-1:0] count,
    output logic          clr,
    output logic          push,
    output logic          push_data,
    output logic          pad,
    output logic          pop_ok,
    output logic          armed,
    output logic          trig_hit
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] LAST_C = CW'(DEPTH - 1);

    trc_state_e state_q, state_nx;
    trc_mode_e  mode_q;
    logic       trig_q;
    logic       arm_set, halt, fill_last, trig_set;

    assign arm_set   = arm_wr && arm_wdata && (mode_in != MODE_RSV);
    assign halt      = arm_wr && !arm_wdata && (state_q != ST_IDLE);
    assign fill_last = (count == LAST_C);
    assign trig_set  = !arm_wr && match && (state_q != ST_IDLE);

    // State register, latched mode and trigger flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_BEGIN;
            trig_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (arm_set) begin
                mode_q <= trc_mode_e'(mode_in);
                trig_q <= 1'b0;
            end else if (trig_set) begin
                trig_q <= 1'b1;
            end
        end
    end

    // Next-state decision
    always_comb begin
        state_nx = state_q;
        if (arm_set) begin
            state_nx = (mode_in == MODE_BEGIN) ? ST_WAIT : ST_RUN;
        end else if (halt) begin
            state_nx = ST_IDLE;
        end else if (!arm_wr) begin
            unique case (state_q)
                ST_IDLE: state_nx = ST_IDLE;
                ST_WAIT: if (match) state_nx = ST_RUN;
                ST_RUN: begin
                    unique case (mode_q)
                        MODE_BEGIN: if (cof_vld && fill_last) state_nx = ST_IDLE;
                        MODE_END:   if (match) state_nx = ST_IDLE;
                        MODE_DATA:  if (match && fill_last) state_nx = ST_IDLE;
                        default:    state_nx = ST_IDLE;
                    endcase
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Outputs toward the storage ring
    always_comb begin
        clr       = arm_set;
        pad       = halt && (count < FULL_C);
        pop_ok    = (state_q == ST_IDLE) && !arm_wr;
        push      = 1'b0;
        push_data = 1'b0;
        if (!arm_wr && state_q == ST_RUN) begin
            unique case (mode_q)
                MODE_BEGIN: push = cof_vld;
                MODE_END:   push = cof_vld && !match;
                MODE_DATA: begin
                    push      = match;
                    push_data = 1'b1;
                end
                default:    push = 1'b0;
            endcase
        end
    end

    assign armed    = (state_q != ST_IDLE);
    assign trig_hit = trig_q;

endmodule

// File: rtl/trc_store.sv
module trc_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [AW-1:0] wdata,
    input  logic          pad,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic [AW-1:0] rd_data
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    logic [AW-1:0] slot_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q, rd_prev;
    logic [CW-1:0] cnt_q;

    assign rd_prev = rd_q - 1'b1;

    // Ring contents: new record at the write slot, or a zero marker just
    // ahead of the oldest record on a manual halt
    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[wr_q] <= wdata;
        end else if (pad) begin
            slot_q[rd_prev] <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (pad) begin
            rd_q  <= rd_prev;
            cnt_q <= cnt_q + 1'b1;
        end else if (push) begin
            wr_q <= wr_q + 1'b1;
            if (cnt_q == FULL_C) begin
                rd_q <= rd_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (pop && cnt_q != '0) begin
            rd_q  <= rd_q + 1'b1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count   = cnt_q;
    assign rd_data = (cnt_q != '0) ? slot_q[rd_q] : '0;

endmodule

// File: rtl/trc_fifo.sv
module trc_fifo #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arm_wr,
    input  logic                   arm_wdata,
    input  logic [1:0]             mode_sel,
    input  logic                   match,
    input  logic                   cof_vld,
    input  logic [AW-1:0]          cof_addr,
    input  logic [DW-1:0]          data_in,
    input  logic                   rd_stb,
    output logic [AW-1:0]          rd_data,
    output logic [$clog2(DEPTH):0] count,
    output logic                   armed,
    output logic                   trig_hit
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic          clr, push, push_data, pad, pop_ok;
    logic [AW-1:0] wdata;

    assign wdata = push_data ? {{(AW-DW){1'b0}}, data_in} : cof_addr;

    trc_ctrl #(.DEPTH(DEPTH), .CW(CW)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_wr    (arm_wr),
        .arm_wdata (arm_wdata),
        .mode_in   (mode_sel),
        .match     (match),
        .cof_vld   (cof_vld),
        .count     (count),
        .clr       (clr),
        .push      (push),
        .push_data (push_data),
        .pad       (pad),
        .pop_ok    (pop_ok),
        .armed     (armed),
        .trig_hit  (trig_hit)
    );

    trc_store #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .CW(CW)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .push    (push),
        .wdata   (wdata),
        .pad     (pad),
        .pop     (rd_stb && pop_ok),
        .count   (count),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/trc_fifo_chk.sv
module trc_fifo_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   arm_wr,
    input logic                   arm_wdata,
    input logic [1:0]             mode_sel,
    input logic                   match,
    input logic                   cof_vld,
    input logic                   rd_stb,
    input logic [AW-1:0]          rd_data,
    input logic [$clog2(DEPTH):0] count,
    input logic                   armed,
    input logic                   trig_hit
);

    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_C); // R6

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr && arm_wdata && mode_sel != 2'b11) |=> (armed && count == '0 && !trig_hit)); // R2

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (rd_data == '0)); // R7

    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !arm_wr && rd_stb && count != '0) |=> (count == $past(count) - 1'b1)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !arm_wr && !rd_stb) |=> $stable(count)); // R10

    AST_RD_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !arm_wr && rd_stb && !match && !cof_vld) |=> $stable(count)); // R8

    AST_HALT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && arm_wr && !arm_wdata && count < FULL_C)
        |=> (!armed && count == $past(count) + 1'b1 && rd_data == '0)); // R9

    AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !arm_wr) |=> trig_hit); // R12

endmodule

bind trc_fifo trc_fifo_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_wr    (arm_wr),
    .arm_wdata (arm_wdata),
    .mode_sel  (mode_sel),
    .match     (match),
    .cof_vld   (cof_vld),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .count     (count),
    .armed     (armed),
    .trig_hit  (trig_hit)
);

// File: tb/trc_fifo_tb_top.sv
module trc_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_wr = 1'b0, arm_wdata = 1'b0, match = 1'b0, cof_vld = 1'b0, rd_stb = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic [15:0] cof_addr = '0;
    logic [7:0]  data_in = '0;
    logic [15:0] rd_data;
    logic [3:0]  count;
    logic        armed, trig_hit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] m_mem [8];
    int          m_wr = 0, m_rd = 0, m_cnt = 0, m_st = 0, m_mode = 0;
    bit          m_trig = 1'b0;

    always #10 clk = ~clk;

    trc_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .arm_wdata(arm_wdata),
        .mode_sel(mode_sel), .match(match), .cof_vld(cof_vld), .cof_addr(cof_addr),
        .data_in(data_in), .rd_stb(rd_stb), .rd_data(rd_data), .count(count),
        .armed(armed), .trig_hit(trig_hit)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic m_push(input logic [15:0] v);
        m_mem[m_wr] = v;
        m_wr = (m_wr + 1) % 8;
        if (m_cnt == 8) m_rd = (m_rd + 1) % 8;
        else m_cnt++;
    endtask

    task automatic m_step(input bit aw, input bit ad, input logic [1:0] md, input bit mt,
                          input bit cv, input logic [15:0] ca, input logic [7:0] dv, input bit rs);
        if (aw && ad && md != 2'b11) begin
            m_st = (md == 2'b00) ? 1 : 2; m_mode = int'(md);
            m_cnt = 0; m_wr = 0; m_rd = 0; m_trig = 1'b0;
        end else if (aw && !ad && m_st != 0) begin
            if (m_cnt < 8) begin
                m_rd = (m_rd + 7) % 8; m_mem[m_rd] = 16'h0; m_cnt++;
            end
            m_st = 0;
        end else if (aw) begin
            // ignored write
        end else if (m_st == 0) begin
            if (rs && m_cnt > 0) begin m_rd = (m_rd + 1) % 8; m_cnt--; end
        end else begin
            if (mt) m_trig = 1'b1;
            if (m_st == 1) begin
                if (mt) m_st = 2;
            end else begin
                case (m_mode)
                    0: if (cv) begin m_push(ca); if (m_cnt == 8) m_st = 0; end
                    1: if (mt) m_st = 0; else if (cv) m_push(ca);
                    default: if (mt) begin m_push({8'h00, dv}); if (m_cnt == 8) m_st = 0; end
                endcase
            end
        end
    endtask

    task automatic cyc(input bit aw, input bit ad, input logic [1:0] md, input bit mt, input bit cv,
                       input logic [15:0] ca, input logic [7:0] dv, input bit rs, input string tag);
        arm_wr = aw; arm_wdata = ad; mode_sel = md; match = mt; cof_vld = cv;
        cof_addr = ca; data_in = dv; rd_stb = rs;
        m_step(aw, ad, md, mt, cv, ca, dv, rs);
        @(posedge clk);
        @(negedge clk);
        chk(tag, "count(R6)", 32'(count), 32'(m_cnt));
        chk(tag, "armed(R2)", 32'(armed), 32'(m_st != 0));
        chk(tag, "rd_data(R7)", 32'(rd_data), (m_cnt != 0) ? 32'(m_mem[m_rd]) : 32'h0);
        chk(tag, "trig_hit(R12)", 32'(trig_hit), 32'(m_trig));
    endtask

    task automatic nop(input string t);                        cyc(0,0,2'b00,0,0,16'h0,8'h0,0,t); endtask
    task automatic arm(input logic [1:0] md, input string t);  cyc(1,1,md,0,0,16'h0,8'h0,0,t);    endtask
    task automatic halt(input string t);                       cyc(1,0,2'b00,0,0,16'h0,8'h0,0,t); endtask
    task automatic cof(input logic [15:0] a, input string t);  cyc(0,0,2'b00,0,1,a,8'h0,0,t);     endtask
    task automatic trg(input logic [7:0] d, input string t);   cyc(0,0,2'b00,1,0,16'h0,d,0,t);    endtask
    task automatic rd(input string t);                         cyc(0,0,2'b00,0,0,16'h0,8'h0,1,t); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (R6 sequence incomplete) act=timeout exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "count", 32'(count), 32'h0);
        chk("R1", "armed", 32'(armed), 32'h0);
        chk("R1", "trig_hit", 32'(trig_hit), 32'h0);
        chk("R1", "rd_data", 32'(rd_data), 32'h0);

        // R2: reserved code refused, valid code accepted
        arm(2'b11, "R2");
        chk("R2", "armed after code 11", 32'(armed), 32'h0);
        arm(2'b00, "R2");
        chk("R2", "armed after code 00", 32'(armed), 32'h1);

        // R3: start-on-trigger
        cof(16'h1111, "R3"); cof(16'h1112, "R3");
        chk("R3", "count before trigger", 32'(count), 32'h0);
        cyc(0,0,2'b00,1,1,16'h2222,8'h0,0,"R3");
        chk("R3", "count after match+cof", 32'(count), 32'h0);
        for (int i = 0; i < 8; i++) cof(16'h3000 + 16'(i), "R3");
        chk("R6", "count full", 32'(count), 32'h8);
        chk("R6", "auto disarm", 32'(armed), 32'h0);
        cof(16'h9999, "R10"); trg(8'h11, "R10");
        chk("R10", "count while idle", 32'(count), 32'h8);
        for (int i = 0; i < 8; i++) begin
            chk("R7", "readout order", 32'(rd_data), 32'h3000 + i);
            rd("R7");
        end
        chk("R7", "empty rd_data", 32'(rd_data), 32'h0);
        rd("R7");
        chk("R7", "empty read count", 32'(count), 32'h0);

        // R8 and R5: data sample mode
        arm(2'b10, "R5");
        trg(8'h5A, "R5");
        rd("R8");
        chk("R8", "read while armed", 32'(count), 32'h1);
        cof(16'h7777, "R5");
        chk("R5", "cof ignored", 32'(count), 32'h1);
        trg(8'hA5, "R5"); trg(8'h3C, "R5");
        // R9: manual halt below full
        halt("R9");
        chk("R9", "count after halt", 32'(count), 32'h4);
        chk("R9", "disarmed", 32'(armed), 32'h0);
        chk("R9", "marker", 32'(rd_data), 32'h0);
        rd("R9");
        chk("R5", "first sample", 32'(rd_data), 32'h005A);
        rd("R5");
        chk("R5", "second sample", 32'(rd_data), 32'h00A5);
        rd("R5");
        chk("R5", "third sample", 32'(rd_data), 32'h003C);
        rd("R5");

        // R4: stop-on-trigger with wrap
        arm(2'b01, "R4");
        for (int i = 1; i <= 11; i++) cof(16'h1000 + 16'(i), "R4");
        chk("R4", "count held at full", 32'(count), 32'h8);
        cyc(0,0,2'b00,1,1,16'h2000,8'h0,0,"R4");
        chk("R4", "disarm on match", 32'(armed), 32'h0);
        chk("R12", "trig seen", 32'(trig_hit), 32'h1);
        for (int i = 4; i <= 11; i++) begin
            chk("R4", "last eight", 32'(rd_data), 32'h1000 + i);
            rd("R4");
        end

        // R9: halt at full gives no marker
        arm(2'b01, "R9");
        for (int i = 0; i <= 8; i++) cof(16'h4000 + 16'(i), "R9");
        halt("R9");
        chk("R9", "full halt count", 32'(count), 32'h8);
        chk("R9", "full halt oldest", 32'(rd_data), 32'h4001);
        for (int i = 0; i < 8; i++) rd("R9");

        // R11: arm write wins over events
        arm(2'b00, "R11");
        cyc(1,1,2'b00,1,0,16'h0,8'h0,0,"R11");
        chk("R11", "trig after arm+match", 32'(trig_hit), 32'h0);
        cof(16'h5555, "R11");
        chk("R11", "still waiting", 32'(count), 32'h0);
        trg(8'h00, "R11");
        cof(16'h6666, "R11");
        cyc(1,0,2'b00,0,1,16'h6667,8'h0,0,"R11");
        chk("R11", "halt with cof", 32'(count), 32'h2);
        rd("R11");
        chk("R11", "kept entry", 32'(rd_data), 32'h6666);
        // R12: hold through idle and refused arm
        nop("R12"); arm(2'b11, "R12");
        chk("R12", "held", 32'(trig_hit), 32'h1);
        arm(2'b10, "R12");
        chk("R12", "cleared by arm", 32'(trig_hit), 32'h0);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            bit aw, ad;
            aw = ($urandom % 25) == 0;
            ad = ($urandom % 3) != 0;
            cyc(aw, ad, 2'($urandom), ($urandom % 5) == 0, ($urandom % 2) == 0,
                16'($urandom), 8'($urandom), ($urandom % 3) == 0, "RAND");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule